// File: doc/BRIEF.md
# Dual Interval Timer

The block holds two independent up-counting interval timers on one small register port. Each timer has a count register, a limit register and a two-bit control register. On each enabled cycle a timer's count goes up by one. When the count equals the limit, the next enabled cycle loads zero, so the period is limit + 1 cycles. If the timer's interrupt-enable bit is set, that same wrap also sets a sticky interrupt flag. The flag stays high until software writes the timer's control register, whatever value is written.

Each timer has a second control bit that qualifies counting with the core's halt input. With the bit set, the timer stops while halt is high. With it clear, the timer counts on every cycle. A limit of all ones turns a timer into a free-running counter that wraps monotonically. Software may rewrite the count at any time. Writing zero restarts the interval from the beginning.

Register access uses a plain strobe interface: an address, write data, a write strobe and a read strobe. Read data is combinational and is valid in the cycle the read strobe is high.

Top module: `dual_interval_timer`

## Requirements
- R1: Timer 0 has count at address 0x21, control at 0x22 and limit at 0x23. Timer 1 has count at 0x100, control at 0x101 and limit at 0x102. A read returns the current value in the same cycle. Control bits 31:2 read as zero. Any other address reads as zero, and read data is zero while the read strobe is low.
- R2: On each enabled cycle the count advances by one, starting from the last value written to it.
- R3: An enabled cycle that finds the count equal to the limit loads zero into the count.
- R4: When control bit 0 (interrupt enable) is 1, a wrap sets the timer's interrupt output on the same clock edge. When it is 0, a wrap leaves the interrupt low.
- R5: A set interrupt stays high through further counting and through writes to the count register.
- R6: Any write to a timer's control register clears that timer's interrupt, whatever the written value.
- R7: When control bit 1 (not-halted) is 1, the timer does not advance while the halt input is high. When it is 0, the timer advances on every cycle regardless of halt.
- R8: With a limit of 0xFFFFFFFF, the count runs through 0xFFFFFFFF and wraps to 0.
- R9: A count write takes effect on the next edge and has priority over counting. A write of zero restarts counting from zero.
- R10: Reset clears both counts, both limits, both control registers and both interrupt flags.
- R11: Register writes to one timer leave the other timer's registers and interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | Core halted indication |
| reg_addr | input | ADDR_W (12) | Register address |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | DATA_W (32) | Read data, combinational |
| irq_o | output | 2 | Sticky interrupt per timer |

## Verification
The assertions check on every cycle, for each timer:
- the single-step increment;
- the load of zero after a wrap;
- the freeze while halted with not-halted set;
- the set, hold and clear rules of the interrupt flag;
- the quiet read bus.

The bench scenarios are needed for behaviour the assertions cannot show:
- the absolute address map and the masking of unused control bits;
- the exact count after a known number of ticks across a wrap;
- the free-running rollover at the top of the range;
- the isolation between the two timers;
- the all-zero state during reset.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // control register layout: bit 0 interrupt enable, bit 1 not-halted
  localparam int CTL_W = 2;

  typedef struct packed {
    logic nh;
    logic ie;
  } tmr_ctl_t;

  // whether a timer may advance this cycle
  function automatic logic tmr_tick(input tmr_ctl_t ctl, input logic halt);
    return (!ctl.nh) || (!halt);
  endfunction
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_cnt,
  output logic              hit_ctl,
  output logic              hit_lim
);
  localparam logic [ADDR_W-1:0] A_CNT = BASE;
  localparam logic [ADDR_W-1:0] A_CTL = BASE + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_LIM = BASE + ADDR_W'(2);

  assign hit_cnt = (addr == A_CNT);
  assign hit_ctl = (addr == A_CTL);
  assign hit_lim = (addr == A_LIM);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_i,
  input  logic              wr_cnt,
  input  logic              wr_ctl,
  input  logic              wr_lim,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] lim_o,
  output tmr_ctl_t          ctl_o,
  output logic              irq_o,
  output logic              tick_o,
  output logic              wrap_o
);
  logic [DATA_W-1:0] cnt_q, lim_q;
  tmr_ctl_t          ctl_q;
  logic              irq_q;
  logic              at_limit;

  assign tick_o   = tmr_tick(ctl_q, halt_i);
  assign at_limit = (cnt_q == lim_q);
  assign wrap_o   = tick_o && at_limit && !wr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_cnt) begin
      cnt_q <= wdata;
    end else if (tick_o) begin
      cnt_q <= at_limit ? '0 : cnt_q + DATA_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '0;
      ctl_q <= '0;
    end else begin
      if (wr_lim) lim_q <= wdata;
      if (wr_ctl) ctl_q <= tmr_ctl_t'(wdata[CTL_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (wr_ctl) begin
      irq_q <= 1'b0;
    end else if (wrap_o && ctl_q.ie) begin
      irq_q <= 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign lim_o = lim_q;
  assign ctl_o = ctl_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
  import tmr_pkg::*;
#(
  parameter int N      = 2,
  parameter int DATA_W = 32
) (
  input  logic                     rd,
  input  logic [N-1:0]             hit_cnt,
  input  logic [N-1:0]             hit_ctl,
  input  logic [N-1:0]             hit_lim,
  input  logic [N-1:0][DATA_W-1:0] cnt,
  input  logic [N-1:0][DATA_W-1:0] lim,
  input  logic [N-1:0][CTL_W-1:0]  ctl,
  output logic [DATA_W-1:0]        rdata
);
  always_comb begin
    rdata = '0;
    if (rd) begin
      for (int i = 0; i < N; i++) begin
        if (hit_cnt[i]) rdata = rdata | cnt[i];
        if (hit_lim[i]) rdata = rdata | lim[i];
        if (hit_ctl[i]) rdata = rdata | {{(DATA_W-CTL_W){1'b0}}, ctl[i]};
      end
    end
  end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] BASE0 = 12'h021,
  parameter logic [ADDR_W-1:0] BASE1 = 12'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [1:0]        irq_o
);
  localparam int NT = 2;

  logic [NT-1:0]             hit_cnt, hit_ctl, hit_lim;
  logic [NT-1:0][DATA_W-1:0] cnt_all, lim_all;
  logic [NT-1:0][CTL_W-1:0]  ctl_all;
  logic [NT-1:0]             tick_all, wrap_all;
  logic [NT-1:0]             cnt_wr_all, ctl_wr_all, lim_wr_all;

  for (genvar g = 0; g < NT; g++) begin : g_tmr
    localparam logic [ADDR_W-1:0] BASE_G = (g == 0) ? BASE0 : BASE1;
    tmr_ctl_t ctl_s;

    tmr_decode #(.ADDR_W(ADDR_W), .BASE(BASE_G)) u_dec (
      .addr    (reg_addr),
      .hit_cnt (hit_cnt[g]),
      .hit_ctl (hit_ctl[g]),
      .hit_lim (hit_lim[g])
    );

    assign cnt_wr_all[g] = reg_wr && hit_cnt[g];
    assign ctl_wr_all[g] = reg_wr && hit_ctl[g];
    assign lim_wr_all[g] = reg_wr && hit_lim[g];

    tmr_channel #(.DATA_W(DATA_W)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .halt_i (halt_i),
      .wr_cnt (cnt_wr_all[g]),
      .wr_ctl (ctl_wr_all[g]),
      .wr_lim (lim_wr_all[g]),
      .wdata  (reg_wdata),
      .cnt_o  (cnt_all[g]),
      .lim_o  (lim_all[g]),
      .ctl_o  (ctl_s),
      .irq_o  (irq_o[g]),
      .tick_o (tick_all[g]),
      .wrap_o (wrap_all[g])
    );
    assign ctl_all[g] = ctl_s;
  end

  tmr_rdmux #(.N(NT), .DATA_W(DATA_W)) u_rd (
    .rd      (reg_rd),
    .hit_cnt (hit_cnt),
    .hit_ctl (hit_ctl),
    .hit_lim (hit_lim),
    .cnt     (cnt_all),
    .lim     (lim_all),
    .ctl     (ctl_all),
    .rdata   (reg_rdata)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int N      = 2,
  parameter int DATA_W = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     halt_i,
  input logic                     reg_rd,
  input logic [DATA_W-1:0]        reg_rdata,
  input logic [N-1:0][DATA_W-1:0] cnt_all,
  input logic [N-1:0][DATA_W-1:0] lim_all,
  input logic [N-1:0][1:0]        ctl_all,
  input logic [N-1:0]             irq,
  input logic [N-1:0]             wrap_all,
  input logic [N-1:0]             cnt_wr_all,
  input logic [N-1:0]             ctl_wr_all
);
  p_rd_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> (reg_rdata == '0));

  for (genvar i = 0; i < N; i++) begin : g_chk
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_wr_all[i] && !(ctl_all[i][1] && halt_i) && (cnt_all[i] != lim_all[i]))
      |=> (cnt_all[i] == $past(cnt_all[i]) + DATA_W'(1)));

    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_all[i] |=> (cnt_all[i] == '0));

    p_irq_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_all[i] && ctl_all[i][0] && !ctl_wr_all[i]) |=> irq[i]);

    p_irq_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq[i] && !(wrap_all[i] && ctl_all[i][0])) |=> !irq[i]);

    p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[i] && !ctl_wr_all[i]) |=> irq[i]);

    p_irq_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr_all[i] |=> !irq[i]);

    p_halt_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_all[i][1] && halt_i && !cnt_wr_all[i]) |=> $stable(cnt_all[i]));
  end
endmodule

bind dual_interval_timer tmr_checker #(.N(2), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .halt_i     (halt_i),
  .reg_rd     (reg_rd),
  .reg_rdata  (reg_rdata),
  .cnt_all    (cnt_all),
  .lim_all    (lim_all),
  .ctl_all    (ctl_all),
  .irq        (irq_o),
  .wrap_all   (wrap_all),
  .cnt_wr_all (cnt_wr_all),
  .ctl_wr_all (ctl_wr_all)
);

// File: tb/dual_interval_timer_tb_top.sv
`timescale 1ns/1ps
module dual_interval_timer_tb_top;
  localparam logic [11:0] T0_CNT = 12'h021, T0_CTL = 12'h022, T0_LIM = 12'h023;
  localparam logic [11:0] T1_CNT = 12'h100, T1_CTL = 12'h101, T1_LIM = 12'h102;
  localparam logic [31:0] C_IE = 32'h1, C_NH = 32'h2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halt_i = 1'b1;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic [1:0]  irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  dual_interval_timer dut_i (
    .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // samples at the current time, away from the clock edge
  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #2;
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  // n rising edges with halt low
  task automatic run(input int n);
    @(negedge clk);
    halt_i = 1'b0;
    repeat (n) @(negedge clk);
    halt_i = 1'b1;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    #3;
    rd(T0_CNT, v); check("R10 t0 count", v, 0);
    rd(T0_CTL, v); check("R10 t0 ctrl", v, 0);
    rd(T0_LIM, v); check("R10 t0 limit", v, 0);
    rd(T1_CNT, v); check("R10 t1 count", v, 0);
    rd(T1_CTL, v); check("R10 t1 ctrl", v, 0);
    rd(T1_LIM, v); check("R10 t1 limit", v, 0);
    check("R10 irq", {30'd0, irq_o}, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_count;
    logic [31:0] v;
    wr(T0_CTL, C_NH); wr(T1_CTL, C_NH);
    wr(T0_LIM, 100); wr(T0_CNT, 5);
    run(10);
    rd(T0_CNT, v); check("R2 count after 10 ticks", v, 15);
    rd(T0_LIM, v); check("R1 limit readback", v, 100);
  endtask

  task automatic t_wrap_noirq;
    logic [31:0] v;
    wr(T0_CTL, C_NH); wr(T0_LIM, 10); wr(T0_CNT, 8);
    run(5);
    rd(T0_CNT, v); check("R3 count after wrap", v, 2);
    check("R4 no irq when disabled", {31'd0, irq_o[0]}, 0);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(T0_CTL, C_NH | C_IE); wr(T0_CNT, 8);
    run(2);
    check("R4 irq before wrap", {31'd0, irq_o[0]}, 0);
    run(1);
    check("R4 irq on wrap", {31'd0, irq_o[0]}, 1);
    rd(T0_CNT, v); check("R3 zero on wrap", v, 0);
    run(5);
    check("R5 irq held while counting", {31'd0, irq_o[0]}, 1);
    wr(T0_CNT, 0);
    check("R5 irq held over count write", {31'd0, irq_o[0]}, 1);
    rd(T0_CNT, v); check("R9 count write zero", v, 0);
    run(4);
    rd(T0_CNT, v); check("R9 restart from zero", v, 4);
  endtask

  task automatic t_ack;
    logic [31:0] v;
    wr(T0_CTL, 32'hFFFF_FFFF);
    check("R6 ctrl write clears irq", {31'd0, irq_o[0]}, 0);
    rd(T0_CTL, v); check("R1 unused ctrl bits zero", v, 3);
    wr(T0_CNT, 10); run(1);
    check("R4 irq again", {31'd0, irq_o[0]}, 1);
    wr(T0_CTL, 0);
    check("R6 clear by zero write", {31'd0, irq_o[0]}, 0);
    rd(12'h024, v); check("R1 unmapped 0x024", v, 0);
    rd(12'h103, v); check("R1 unmapped 0x103", v, 0);
    wr(T0_CTL, C_NH);
  endtask

  task automatic t_halt;
    logic [31:0] v;
    wr(T1_CTL, 0); wr(T1_LIM, 1000); wr(T1_CNT, 0);
    repeat (7) @(negedge clk);
    rd(T1_CNT, v); check("R7 counts while halted, nh=0", v, 7);
    wr(T1_CTL, C_NH); wr(T1_CNT, 40);
    repeat (7) @(negedge clk);
    rd(T1_CNT, v); check("R7 frozen while halted, nh=1", v, 40);
    run(4);
    rd(T1_CNT, v); check("R7 runs when halt low", v, 44);
  endtask

  task automatic t_free;
    logic [31:0] v;
    wr(T1_CTL, C_NH | C_IE); wr(T1_LIM, 32'hFFFF_FFFF); wr(T1_CNT, 32'hFFFF_FFFE);
    run(1);
    rd(T1_CNT, v); check("R8 top of range", v, 32'hFFFF_FFFF);
    run(2);
    rd(T1_CNT, v); check("R8 rollover", v, 1);
    check("R8 irq on rollover", {31'd0, irq_o[1]}, 1);
  endtask

  task automatic t_indep;
    logic [31:0] v;
    wr(T0_CNT, 77); wr(T0_LIM, 500); wr(T0_CTL, C_NH);
    rd(T1_CNT, v); check("R11 t1 count untouched", v, 1);
    rd(T1_LIM, v); check("R11 t1 limit untouched", v, 32'hFFFF_FFFF);
    rd(T1_CTL, v); check("R11 t1 ctrl untouched", v, 3);
    check("R11 t1 irq untouched", {31'd0, irq_o[1]}, 1);
    rd(T0_CNT, v); check("R1 t0 count readback", v, 77);
  endtask

  initial begin
    t_reset;
    t_count;
    t_wrap_noirq;
    t_irq;
    t_ack;
    t_halt;
    t_free;
    t_indep;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule